// File: doc/BRIEF.md
# Folded Polynomial Term Lookup

This block produces one term of a piecewise polynomial approximation with a single lookup table. A fixed-point argument is cut into a sub-interval index (upper bits) and an offset inside that sub-interval (lower bits). The term is modelled as `K(i) * c^DEG`. Here `i` is a truncated index, `K(i) = COEF_BASE + COEF_STEP*i`, and `c` is the offset centred on the middle of the sub-interval. The table only covers offsets in the upper half. The lower half is served by mirroring the offset bits, and for odd degrees by inverting the table output.

A full approximator places several of these units side by side and feeds their outputs to one adder at the extended internal precision. Table entries are computed at elaboration by a constant function, so one parameter set fully defines the contents. An optional output register trades one cycle of latency for a registered output. By default the block is purely combinational.

Top module: `folded_term_table`

## Requirements
- R1: Only the top `IDX_K` bits of the `IDX_W`-bit index field (`x_i[W_IN-1 -: IDX_K]`) and the top `OFF_K` bits of the offset field (`x_i[W_IN-IDX_W-1 -: OFF_K]`) affect `term_o`. All other input bits have no effect.
- R2: The offset MSB `h` selects the half of the sub-interval. With `h=1` the remaining `OFF_K-1` offset bits `r` address the table unchanged. With `h=0` the address uses `~r`. The table address is `{index, folded r}`, giving `2^(IDX_K+OFF_K-1)` entries.
- R3: For an even `DEG`, `term_o` equals the stored entry for both halves, so two mirrored offsets give the same output.
- R4: For an odd `DEG`, `term_o` equals the stored entry when `h=1` and its bitwise inverse (ones' complement, `-e-1`) when `h=0`.
- R5: The entry for truncated index `i` and folded bits `r` is `(K(i)*(2r+1)^DEG + 2^(SHIFT-1)) >>> SHIFT`. Coefficients are non-negative, so every entry is non-negative.
- R6: `term_o` is an `OUT_W`-bit two's-complement value. Its sign bit is clear for even terms. For odd terms it is set exactly when `h=0`.
- R7: For every input, `term_o` equals an unfolded model. That model takes the signed centred offset `c = 2*b+1-2^OFF_K`, where `b` is the top `OFF_K` offset bits. It rounds `K(i)*|c|^DEG` as in R5, then inverts the result for a negative odd-degree product. Folding adds no error.
- R8: With `REG_OUT=1`, `term_o` shows the result for the input sampled at the previous rising edge of `clk_i`. While `rst_ni` is low, `term_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| x_i | input | W_IN | Fixed-point argument: index field over offset field |
| term_o | output | OUT_W | Signed term at extended internal precision |

## Verification
The offset fold and the odd-degree sign restore are both driven by the same offset MSB. Both therefore act in the same evaluation whenever that bit is 0. A sweep over all 256 arguments runs for an odd-degree and an even-degree instance, which provokes every mirrored address under both settings of the sign row. Each output is judged against the unfolded signed-offset model. Pairs of mirrored arguments are also compared against each other, which shows that the magnitude is shared and only the sign differs.

// File: rtl/ftt_pkg.sv
package ftt_pkg;

  // Rounded table entry: (K(idx) * (2*rem+1)^deg) scaled down by 2^shift
  function automatic longint term_entry(longint idx, longint rem, longint base,
                                        longint step, int deg, int shift);
    longint c;
    longint p;
    longint v;
    c = 2 * rem + 1;
    p = 1;
    for (int i = 0; i < deg; i++) p = p * c;
    v = (base + step * idx) * p;
    if (shift > 0) v = (v + (longint'(1) << (shift - 1))) >>> shift;
    return v;
  endfunction

endpackage

// File: rtl/ftt_fold.sv
module ftt_fold #(
  parameter int OFF_K = 3
) (
  input  logic [OFF_K-1:0] off_i,
  output logic             half_o,
  output logic [OFF_K-2:0] fold_o
);
  assign half_o = off_i[OFF_K-1];

  // mirror row: lower half reads the upper-half entry
  for (genvar b = 0; b < OFF_K - 1; b++) begin : g_xor
    assign fold_o[b] = off_i[b] ^ ~half_o;
  end
endmodule

// File: rtl/ftt_rom.sv
module ftt_rom #(
  parameter int     IDX_K     = 3,
  parameter int     OFF_K     = 3,
  parameter int     OUT_W     = 16,
  parameter int     DEG       = 3,
  parameter longint COEF_BASE = 40,
  parameter longint COEF_STEP = 9,
  parameter int     SHIFT     = 2,
  localparam int    AW        = IDX_K + OFF_K - 1,
  localparam int    DEPTH     = 1 << AW
) (
  input  logic [AW-1:0]    addr_i,
  output logic [OUT_W-1:0] data_o
);
  logic [OUT_W-1:0] tbl [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam longint IDX = longint'(e >> (OFF_K - 1));
    localparam longint REM = longint'(e % (1 << (OFF_K - 1)));
    assign tbl[e] = OUT_W'(ftt_pkg::term_entry(IDX, REM, COEF_BASE, COEF_STEP,
                                               DEG, SHIFT));
  end

  assign data_o = tbl[addr_i];
endmodule

// File: rtl/ftt_sign.sv
module ftt_sign #(
  parameter int OUT_W = 16,
  parameter int DEG   = 3
) (
  input  logic [OUT_W-1:0] data_i,
  input  logic             half_i,
  output logic [OUT_W-1:0] term_o
);
  if (DEG % 2 == 1) begin : g_odd
    // ones' complement restores the sign of the lower half
    for (genvar b = 0; b < OUT_W; b++) begin : g_xor
      assign term_o[b] = data_i[b] ^ ~half_i;
    end
  end else begin : g_even
    logic unused_half;
    assign unused_half = half_i;
    assign term_o = data_i;
  end
endmodule

// File: rtl/folded_term_table.sv
module folded_term_table #(
  parameter int     W_IN      = 8,
  parameter int     IDX_W     = 4,
  parameter int     IDX_K     = 3,
  parameter int     OFF_K     = 3,
  parameter int     OUT_W     = 16,
  parameter int     DEG       = 3,
  parameter longint COEF_BASE = 40,
  parameter longint COEF_STEP = 9,
  parameter int     SHIFT     = 2,
  parameter bit     REG_OUT   = 1'b0,
  localparam int    OFF_W     = W_IN - IDX_W,
  localparam int    AW        = IDX_K + OFF_K - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W_IN-1:0]  x_i,
  output logic [OUT_W-1:0] term_o
);
  logic [IDX_K-1:0] idx_k;
  logic [OFF_K-1:0] off_k;
  logic             half;
  logic [OFF_K-2:0] fold;
  logic [OUT_W-1:0] entry;
  logic [OUT_W-1:0] term_d;

  assign idx_k = x_i[W_IN-1 -: IDX_K];
  assign off_k = x_i[OFF_W-1 -: OFF_K];

  ftt_fold #(.OFF_K(OFF_K)) u_fold (
    .off_i (off_k),
    .half_o(half),
    .fold_o(fold)
  );

  ftt_rom #(
    .IDX_K(IDX_K), .OFF_K(OFF_K), .OUT_W(OUT_W), .DEG(DEG),
    .COEF_BASE(COEF_BASE), .COEF_STEP(COEF_STEP), .SHIFT(SHIFT)
  ) u_rom (
    .addr_i({idx_k, fold}),
    .data_o(entry)
  );

  ftt_sign #(.OUT_W(OUT_W), .DEG(DEG)) u_sign (
    .data_i(entry),
    .half_i(half),
    .term_o(term_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) term_o <= '0;
      else         term_o <= term_d;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign term_o = term_d;
  end

  // truncated address bits are dropped on purpose
  logic unused_x;
  assign unused_x = ^x_i;
endmodule

// File: rtl/folded_term_table_chk.sv
module folded_term_table_chk #(
  parameter int W_IN    = 8,
  parameter int IDX_W   = 4,
  parameter int IDX_K   = 3,
  parameter int OFF_K   = 3,
  parameter int OUT_W   = 16,
  parameter int DEG     = 3,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [W_IN-1:0]  x_i,
  input logic [OUT_W-1:0] term_o
);
  localparam int OFF_W = W_IN - IDX_W;
  localparam int KW    = IDX_K + OFF_K;
  localparam logic [1:0] NEED_SIGN = REG_OUT ? 2'd1 : 2'd0;
  localparam logic [1:0] NEED_STAB = REG_OUT ? 2'd2 : 2'd1;

  logic [1:0]      age_q;
  logic [W_IN-1:0] x_q;
  logic [W_IN-1:0] x_eff;
  logic [KW-1:0]   key_eff;
  logic [KW-1:0]   key_q;
  logic            half_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      x_q   <= '0;
      key_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      x_q   <= x_i;
      key_q <= key_eff;
    end
  end

  assign x_eff    = REG_OUT ? x_q : x_i;
  assign key_eff  = {x_eff[W_IN-1 -: IDX_K], x_eff[OFF_W-1 -: OFF_K]};
  assign half_eff = x_eff[OFF_W-1];

  // R1
  ignored_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= NEED_STAB && key_eff == key_q) |-> $stable(term_o));

  // R4
  odd_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEG % 2 == 1 && age_q >= NEED_SIGN) |-> (term_o[OUT_W-1] == !half_eff));

  // R6
  even_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEG % 2 == 0 && age_q >= NEED_SIGN) |-> !term_o[OUT_W-1]);

  // R8
  always_comb begin
    if (REG_OUT && rst_ni === 1'b0) reset_zero_chk: assert (term_o == '0);
  end
endmodule

bind folded_term_table folded_term_table_chk #(
  .W_IN(W_IN), .IDX_W(IDX_W), .IDX_K(IDX_K), .OFF_K(OFF_K),
  .OUT_W(OUT_W), .DEG(DEG), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/folded_term_table_test.sv
module folded_term_table_test;
  localparam int W_IN = 8, IDX_W = 4, IDX_K = 3, OFF_K = 3, OUT_W = 16;
  localparam longint BASE = 40, STEP = 9;
  localparam int SHIFT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W_IN-1:0] x = '0;
  logic [OUT_W-1:0] t_odd, t_even, t_reg;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  folded_term_table #(.DEG(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .term_o(t_odd));
  folded_term_table #(.DEG(2)) u_even (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .term_o(t_even));
  folded_term_table #(.DEG(3), .REG_OUT(1'b1)) u_reg (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .term_o(t_reg));

  // unfolded model over the signed centred offset
  function automatic logic [OUT_W-1:0] model(logic [W_IN-1:0] xv, int deg);
    longint i, b, c, mag, p, v;
    i = longint'(xv[W_IN-1 -: IDX_K]);
    b = longint'(xv[W_IN-IDX_W-1 -: OFF_K]);
    c = 2 * b + 1 - (1 << OFF_K);
    mag = (c < 0) ? -c : c;
    p = 1;
    for (int k = 0; k < deg; k++) p = p * mag;
    v = ((BASE + STEP * i) * p + (1 << (SHIFT - 1))) >>> SHIFT;
    if (c < 0 && (deg % 2 == 1)) v = -v - 1;
    return OUT_W'(v);
  endfunction

  task automatic check(string req, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [OUT_W-1:0] a0;
    logic [OUT_W-1:0] a1;
    // R8 reset state
    x = 8'hA5;
    repeat (3) @(negedge clk);
    check("R8 reset", t_reg, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 R3 R4 R8 exhaustive sweep
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      x = W_IN'(v);
      #1;
      check("R7 odd", t_odd, model(x, 3));
      check("R3 even", t_even, model(x, 2));
      @(posedge clk);
      #1;
      check("R8 reg", t_reg, model(x, 3));
    end

    // R5 explicit entry: i=7, r=3, h=1 -> (103*343+2)>>2 = 8832
    @(negedge clk);
    x = 8'b111_0_111_0;
    #1;
    check("R5 entry", t_odd, 16'd8832);
    // R4 lower half mirror of it -> ones' complement
    x = 8'b111_0_000_0;
    #1;
    check("R4 invert", t_odd, ~16'd8832);
    // R2 lowest entry: i=0, r=0 -> (40+2)>>2 = 10 via both halves
    x = 8'b000_0_100_0;
    #1;
    check("R2 upper", t_even, 16'd10);
    x = 8'b000_0_011_0;
    #1;
    check("R2 mirror", t_even, 16'd10);

    // R1 ignored bits and R3/R4 mirrored pairs
    for (int v = 0; v < 256; v += 7) begin
      @(negedge clk);
      x = W_IN'(v);
      #1;
      a0 = t_odd;
      a1 = t_even;
      x = x ^ 8'b000_1_000_1;
      #1;
      check("R1 odd", t_odd, a0);
      check("R1 even", t_even, a1);
      x = x ^ 8'b000_0_011_0;
      x[3] = ~x[3];
      #1;
      check("R4 pair", t_odd, ~a0);
      check("R3 pair", t_even, a1);
    end

    // R6 sign bits across the sweep
    for (int v = 0; v < 256; v += 5) begin
      @(negedge clk);
      x = W_IN'(v);
      #1;
      check("R6 odd sign", {15'd0, t_odd[OUT_W-1]}, {15'd0, ~x[3]});
      check("R6 even sign", {15'd0, t_even[OUT_W-1]}, 16'd0);
    end

    finish_run();
  end
endmodule